// File: doc/BRIEF.md
# Partial-Field Word Aligner

This block applies a field specification to a sign-magnitude machine word: a sign bit and five six-bit bytes. Byte 0 is the sign and bytes 1 to 5 run from most to least significant. It serves a processor datapath that has already fetched the memory word and read the register. It supports five operations:

- **load:** the selected memory bytes are right-justified into a cleared register.
- **load-negative:** a load followed by a sign flip.
- **store:** the low-order register bytes are merged into the selected bytes of the memory word.
- **store-zero:** a store whose source is positive zero.
- **compare:** the same byte range of both words is compared as signed numbers.

The field byte holds two octal digits. The left bound L is in bits [5:3] and the right bound R is in bits [2:0]. The sign takes part only when L is 0. A width select marks the register as a two-byte index register. A load then flags an error if data would reach bytes 1 to 3, and a store or compare treats those register bytes as zero.

Inputs are accepted on a cycle with `in_valid` high. The results are registered and appear with `out_valid` one clock later. A word is carried as bit [30] = sign (1 = negative) and bits [29:0] = magnitude, with byte k held in bits [(5-k)*6 +: 6].

Top module: `field_aligner`

## Requirements
- R1: Outputs update one clock after a cycle with `in_valid` high, and `out_valid` is high in exactly that following cycle. Without `in_valid` the outputs `result`, `cmp_code` and `err` hold. After reset every output is zero.
- R2: Load (op 3'b000) gives positive zero, then the memory sign if L is 0, then memory bytes max(L,1)..R placed right-justified in the lowest register bytes. For example, field 2:4 of +(11,22,33,44,55) gives +(0,0,22,33,44).
- R3: Load-negative (op 3'b001) inverts the sign of the ordinary load, so a field without the sign yields a negative result.
- R4: Store (op 3'b010) returns the memory word with only bytes L..R changed. Bytes max(L,1)..R receive the register's lowest-order bytes in order, and the sign is replaced by the register sign only when L is 0.
- R5: Store-zero (op 3'b011) writes positive zero into the selected field with the same merge rule as store; the register value has no effect.
- R6: Compare (op 3'b100) compares bytes max(L,1)..R of register and memory as signed values. Both sides are taken as positive when L is not 0. `cmp_code` is 2'b00 EQUAL, 2'b01 LESS (register smaller), 2'b10 GREATER. `result` returns the register unchanged. `cmp_code` is 2'b00 for every other op.
- R7: In a compare, a zero field is equal to a zero field whatever the signs, so field 0:0 always gives EQUAL.
- R8: With `idx_sel` high, a load always clears result bytes 1 to 3, and raises `err` when the loaded value would put nonzero data there.
- R9: With `idx_sel` high, store and compare treat register bytes 1 to 3 as zero.
- R10: A field with R > 5 or L > R, or an op code of 3'b101 to 3'b111, raises `err`, returns the unmodified destination (memory for store and store-zero, register otherwise) and gives `cmp_code` 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 3 | Operation code |
| field | input | 6 | Field byte, L in [5:3], R in [2:0] |
| idx_sel | input | 1 | Register is a two-byte index register |
| reg_val | input | 31 | Register word |
| mem_val | input | 31 | Memory word |
| out_valid | output | 1 | Registered results valid |
| result | output | 31 | Loaded register, merged memory word, or register echo |
| cmp_code | output | 2 | Compare outcome |
| err | output | 1 | Field, op or index-width error |

## Verification
The index-width error and the right-justified load value are produced in the same cycle. The error must not suppress or corrupt the value, so loads into an index register are given fields that do and do not reach bytes 1 to 3, and `result` and `err` are judged together in one sample. Invalid fields likewise raise `err` in the same cycle as the destination is echoed. Each case is checked against both the echoed word and the flag.

// File: rtl/fa_pkg.sv
package fa_pkg;

  typedef enum logic [2:0] {
    FOP_LOAD  = 3'd0,
    FOP_LOADN = 3'd1,
    FOP_STORE = 3'd2,
    FOP_STZ   = 3'd3,
    FOP_CMP   = 3'd4
  } fop_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_LT = 2'b01,
    CMP_GT = 2'b10
  } cmp_e;

endpackage

// File: rtl/fa_field_decode.sv
module fa_field_decode #(
  parameter int BYTE_W  = 6,
  parameter int NBYTES  = 5,
  parameter int FIELD_W = 6,
  localparam int DIG_W  = FIELD_W / 2,
  localparam int MAG_W  = NBYTES * BYTE_W,
  localparam int SHB_W  = $clog2(MAG_W + 1)
) (
  input  logic [FIELD_W-1:0] field,
  output logic               valid,
  output logic               sign_in,
  output logic [MAG_W-1:0]   mag_mask,
  output logic [SHB_W-1:0]   shamt
);

  logic [DIG_W-1:0] left_b;
  logic [DIG_W-1:0] right_b;
  logic [DIG_W-1:0] left_eff;

  always_comb begin
    left_b   = field[FIELD_W-1:DIG_W];
    right_b  = field[DIG_W-1:0];
    valid    = (32'(right_b) <= NBYTES) && (left_b <= right_b);
    sign_in  = valid && (left_b == '0);
    left_eff = (left_b == '0) ? DIG_W'(1) : left_b;
    if (valid) shamt = SHB_W'(NBYTES - 32'(right_b)) * SHB_W'(BYTE_W);
    else       shamt = '0;
  end

  // one select per magnitude byte; slot s holds byte number NBYTES - s
  for (genvar s = 0; s < NBYTES; s++) begin : g_slot
    logic sel;
    always_comb begin
      sel = valid && (32'(left_eff) <= (NBYTES - s)) && ((NBYTES - s) <= 32'(right_b));
    end
    assign mag_mask[s*BYTE_W +: BYTE_W] = {BYTE_W{sel}};
  end

endmodule

// File: rtl/fa_load_align.sv
module fa_load_align #(
  parameter int BYTE_W    = 6,
  parameter int NBYTES    = 5,
  parameter int IDX_BYTES = 2,
  localparam int MAG_W    = NBYTES * BYTE_W,
  localparam int SHB_W    = $clog2(MAG_W + 1),
  localparam int LO_W     = IDX_BYTES * BYTE_W
) (
  input  logic [MAG_W-1:0] mem_mag,
  input  logic             mem_sgn,
  input  logic [MAG_W-1:0] mag_mask,
  input  logic [SHB_W-1:0] shamt,
  input  logic             sign_in,
  input  logic             negate,
  input  logic             idx_sel,
  output logic [MAG_W-1:0] res_mag,
  output logic             res_sgn,
  output logic             idx_err
);

  localparam logic [MAG_W-1:0] LO_MASK = {{(MAG_W-LO_W){1'b0}}, {LO_W{1'b1}}};

  logic [MAG_W-1:0] picked;
  logic [MAG_W-1:0] justified;

  always_comb begin
    picked    = mem_mag & mag_mask;
    justified = picked >> shamt;
    idx_err   = idx_sel && ((justified & ~LO_MASK) != '0);
    res_mag   = idx_sel ? (justified & LO_MASK) : justified;
    res_sgn   = (sign_in & mem_sgn) ^ negate;
  end

endmodule

// File: rtl/fa_store_merge.sv
module fa_store_merge #(
  parameter int BYTE_W    = 6,
  parameter int NBYTES    = 5,
  parameter int IDX_BYTES = 2,
  localparam int MAG_W    = NBYTES * BYTE_W,
  localparam int SHB_W    = $clog2(MAG_W + 1),
  localparam int LO_W     = IDX_BYTES * BYTE_W
) (
  input  logic [MAG_W-1:0] dst_mag,
  input  logic             dst_sgn,
  input  logic [MAG_W-1:0] src_mag,
  input  logic             src_sgn,
  input  logic [MAG_W-1:0] mag_mask,
  input  logic [SHB_W-1:0] shamt,
  input  logic             sign_in,
  input  logic             zero_src,
  input  logic             idx_sel,
  output logic [MAG_W-1:0] res_mag,
  output logic             res_sgn
);

  localparam logic [MAG_W-1:0] LO_MASK = {{(MAG_W-LO_W){1'b0}}, {LO_W{1'b1}}};

  logic [MAG_W-1:0] src_eff;
  logic [MAG_W-1:0] placed;

  always_comb begin
    if (zero_src)     src_eff = '0;
    else if (idx_sel) src_eff = src_mag & LO_MASK;
    else              src_eff = src_mag;
    placed  = src_eff << shamt;
    res_mag = (dst_mag & ~mag_mask) | (placed & mag_mask);
    res_sgn = sign_in ? (src_sgn & ~zero_src) : dst_sgn;
  end

endmodule

// File: rtl/fa_compare.sv
module fa_compare
  import fa_pkg::*;
#(
  parameter int BYTE_W    = 6,
  parameter int NBYTES    = 5,
  parameter int IDX_BYTES = 2,
  localparam int MAG_W    = NBYTES * BYTE_W,
  localparam int LO_W     = IDX_BYTES * BYTE_W
) (
  input  logic [MAG_W-1:0] reg_mag,
  input  logic             reg_sgn,
  input  logic [MAG_W-1:0] mem_mag,
  input  logic             mem_sgn,
  input  logic [MAG_W-1:0] mag_mask,
  input  logic             sign_in,
  input  logic             idx_sel,
  output cmp_e             outcome
);

  localparam logic [MAG_W-1:0] LO_MASK = {{(MAG_W-LO_W){1'b0}}, {LO_W{1'b1}}};

  logic [MAG_W-1:0] a_mag;
  logic [MAG_W-1:0] b_mag;
  logic             a_neg;
  logic             b_neg;

  always_comb begin
    a_mag = (idx_sel ? (reg_mag & LO_MASK) : reg_mag) & mag_mask;
    b_mag = mem_mag & mag_mask;
    a_neg = sign_in && reg_sgn && (a_mag != '0);
    b_neg = sign_in && mem_sgn && (b_mag != '0);
    if (a_neg != b_neg)  outcome = a_neg ? CMP_LT : CMP_GT;
    else if (a_mag == b_mag) outcome = CMP_EQ;
    else if ((a_mag < b_mag) ^ a_neg) outcome = CMP_LT;
    else                 outcome = CMP_GT;
  end

endmodule

// File: rtl/field_aligner.sv
module field_aligner
  import fa_pkg::*;
#(
  parameter int BYTE_W    = 6,
  parameter int NBYTES    = 5,
  parameter int IDX_BYTES = 2,
  parameter int FIELD_W   = 6,
  localparam int MAG_W    = NBYTES * BYTE_W,
  localparam int WORD_W   = MAG_W + 1,
  localparam int SHB_W    = $clog2(MAG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [FIELD_W-1:0] field,
  input  logic              idx_sel,
  input  logic [WORD_W-1:0] reg_val,
  input  logic [WORD_W-1:0] mem_val,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic [1:0]        cmp_code,
  output logic              err
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             f_valid;
  logic             f_sign;
  logic [MAG_W-1:0] f_mask;
  logic [SHB_W-1:0] f_shamt;

  fa_field_decode #(
    .BYTE_W (BYTE_W),
    .NBYTES (NBYTES),
    .FIELD_W(FIELD_W)
  ) u_decode (
    .field   (field),
    .valid   (f_valid),
    .sign_in (f_sign),
    .mag_mask(f_mask),
    .shamt   (f_shamt)
  );

  logic [MAG_W-1:0] ld_mag;
  logic             ld_sgn;
  logic             ld_err;

  fa_load_align #(
    .BYTE_W   (BYTE_W),
    .NBYTES   (NBYTES),
    .IDX_BYTES(IDX_BYTES)
  ) u_load (
    .mem_mag (mem_val[MAG_W-1:0]),
    .mem_sgn (mem_val[MAG_W]),
    .mag_mask(f_mask),
    .shamt   (f_shamt),
    .sign_in (f_sign),
    .negate  (op == FOP_LOADN),
    .idx_sel (idx_sel),
    .res_mag (ld_mag),
    .res_sgn (ld_sgn),
    .idx_err (ld_err)
  );

  logic [MAG_W-1:0] st_mag;
  logic             st_sgn;

  fa_store_merge #(
    .BYTE_W   (BYTE_W),
    .NBYTES   (NBYTES),
    .IDX_BYTES(IDX_BYTES)
  ) u_store (
    .dst_mag (mem_val[MAG_W-1:0]),
    .dst_sgn (mem_val[MAG_W]),
    .src_mag (reg_val[MAG_W-1:0]),
    .src_sgn (reg_val[MAG_W]),
    .mag_mask(f_mask),
    .shamt   (f_shamt),
    .sign_in (f_sign),
    .zero_src(op == FOP_STZ),
    .idx_sel (idx_sel),
    .res_mag (st_mag),
    .res_sgn (st_sgn)
  );

  cmp_e cmp_out;

  fa_compare #(
    .BYTE_W   (BYTE_W),
    .NBYTES   (NBYTES),
    .IDX_BYTES(IDX_BYTES)
  ) u_cmp (
    .reg_mag (reg_val[MAG_W-1:0]),
    .reg_sgn (reg_val[MAG_W]),
    .mem_mag (mem_val[MAG_W-1:0]),
    .mem_sgn (mem_val[MAG_W]),
    .mag_mask(f_mask),
    .sign_in (f_sign),
    .idx_sel (idx_sel),
    .outcome (cmp_out)
  );

  // next-state selection
  logic [WORD_W-1:0] res_d;
  logic [1:0]        cmp_d;
  logic              err_d;

  always_comb begin
    res_d = reg_val;
    cmp_d = CMP_EQ;
    err_d = 1'b0;
    case (op)
      FOP_LOAD, FOP_LOADN: begin
        if (f_valid) begin
          res_d = {ld_sgn, ld_mag};
          err_d = ld_err;
        end else begin
          err_d = 1'b1;
        end
      end
      FOP_STORE, FOP_STZ: begin
        if (f_valid) res_d = {st_sgn, st_mag};
        else begin
          res_d = mem_val;
          err_d = 1'b1;
        end
      end
      FOP_CMP: begin
        if (f_valid) cmp_d = cmp_out;
        else         err_d = 1'b1;
      end
      default: err_d = 1'b1;
    endcase
  end

  // output registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cmp_code  <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res_d;
        cmp_code <= cmp_d;
        err      <= err_d;
      end
    end
  end

endmodule

// File: rtl/field_aligner_chk.sv
module field_aligner_chk #(
  parameter int BYTE_W    = 6,
  parameter int NBYTES    = 5,
  parameter int IDX_BYTES = 2,
  localparam int MAG_W    = NBYTES * BYTE_W,
  localparam int WORD_W   = MAG_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [5:0]        field,
  input logic              idx_sel,
  input logic [WORD_W-1:0] mem_val,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic [1:0]        cmp_code,
  input logic              err
);

  logic bad_field;
  assign bad_field = (field[2:0] > 3'(NBYTES)) || (field[5:3] > field[2:0]);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(cmp_code) && $stable(err)));

  // R6
  cmp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cmp_code != 2'b11));

  // R6
  cmp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op != 3'b100)) |=> (cmp_code == 2'b00));

  // R4
  store_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 3'b010) && !bad_field && (field[5:3] != 3'd0))
      |=> (result[MAG_W] == $past(mem_val[MAG_W])));

  // R8
  idx_load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_sel && (op[2:1] == 2'b00))
      |=> (result[MAG_W-1:IDX_BYTES*BYTE_W] == '0));

  // R10
  bad_field_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bad_field) |=> err);

endmodule

bind field_aligner field_aligner_chk #(
  .BYTE_W   (BYTE_W),
  .NBYTES   (NBYTES),
  .IDX_BYTES(IDX_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .op       (op),
  .field    (field),
  .idx_sel  (idx_sel),
  .mem_val  (mem_val),
  .out_valid(out_valid),
  .result   (result),
  .cmp_code (cmp_code),
  .err      (err)
);

// File: tb/field_aligner_tb.sv
module field_aligner_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 27;

  function automatic logic [30:0] w(input logic s, input int b1, input int b2,
                                    input int b3, input int b4, input int b5);
    return {s, 6'(b1), 6'(b2), 6'(b3), 6'(b4), 6'(b5)};
  endfunction

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  fld;
    logic        idx;
    logic [30:0] rv;
    logic [30:0] mv;
    logic [30:0] er;
    logic [1:0]  ec;
    logic        ee;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [30:0] MW = {1'b0, 6'd11, 6'd22, 6'd33, 6'd44, 6'd55};
  localparam logic [30:0] NW = {1'b1, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5};
  localparam logic [30:0] PW = {1'b0, 6'd7, 6'd8, 6'd9, 6'd10, 6'd12};

  localparam vec_t VEC [NVEC] = '{
    // R2 loads
    '{3'd0, 6'o05, 1'b0, PW, MW, MW,                   2'b00, 1'b0, 4'd2},
    '{3'd0, 6'o24, 1'b0, PW, MW, w(0,0,0,22,33,44),    2'b00, 1'b0, 4'd2},
    '{3'd0, 6'o02, 1'b0, PW, NW, w(1,0,0,0,1,2),       2'b00, 1'b0, 4'd2},
    '{3'd0, 6'o00, 1'b0, PW, NW, w(1,0,0,0,0,0),       2'b00, 1'b0, 4'd2},
    // R3 load-negative
    '{3'd1, 6'o15, 1'b0, PW, MW, w(1,11,22,33,44,55),  2'b00, 1'b0, 4'd3},
    '{3'd1, 6'o05, 1'b0, PW, NW, w(0,1,2,3,4,5),       2'b00, 1'b0, 4'd3},
    // R4 stores
    '{3'd2, 6'o02, 1'b0, PW, NW, w(0,10,12,3,4,5),     2'b00, 1'b0, 4'd4},
    '{3'd2, 6'o44, 1'b0, PW, NW, w(1,1,2,3,12,5),      2'b00, 1'b0, 4'd4},
    '{3'd2, 6'o05, 1'b0, PW, NW, PW,                   2'b00, 1'b0, 4'd4},
    // R5 store-zero
    '{3'd3, 6'o13, 1'b0, PW, NW, w(1,0,0,0,4,5),       2'b00, 1'b0, 4'd5},
    '{3'd3, 6'o00, 1'b0, PW, NW, w(0,1,2,3,4,5),       2'b00, 1'b0, 4'd5},
    // R6 compares
    '{3'd4, 6'o05, 1'b0, PW, MW, PW,                   2'b01, 1'b0, 4'd6},
    '{3'd4, 6'o55, 1'b0, NW, MW, NW,                   2'b01, 1'b0, 4'd6},
    '{3'd4, 6'o05, 1'b0, MW, NW, MW,                   2'b10, 1'b0, 4'd6},
    '{3'd4, 6'o13, 1'b0, w(0,11,22,33,0,0), MW, w(0,11,22,33,0,0), 2'b00, 1'b0, 4'd6},
    // R7 signed zeros
    '{3'd4, 6'o04, 1'b0, w(1,0,0,0,0,9), w(0,0,0,0,0,0), w(1,0,0,0,0,9), 2'b00, 1'b0, 4'd7},
    '{3'd4, 6'o00, 1'b0, NW, MW, NW,                   2'b00, 1'b0, 4'd7},
    // R8 index loads
    '{3'd0, 6'o05, 1'b1, PW, MW, w(0,0,0,0,44,55),     2'b00, 1'b1, 4'd8},
    '{3'd0, 6'o45, 1'b1, PW, MW, w(0,0,0,0,44,55),     2'b00, 1'b0, 4'd8},
    '{3'd0, 6'o02, 1'b1, PW, NW, w(1,0,0,0,1,2),       2'b00, 1'b0, 4'd8},
    '{3'd0, 6'o13, 1'b1, PW, MW, w(0,0,0,0,22,33),     2'b00, 1'b1, 4'd8},
    // R9 index store and compare
    '{3'd2, 6'o05, 1'b1, MW, NW, w(0,0,0,0,44,55),     2'b00, 1'b0, 4'd9},
    '{3'd4, 6'o05, 1'b1, MW, w(0,0,0,0,44,55), MW,     2'b00, 1'b0, 4'd9},
    // R10 bad field / op
    '{3'd0, 6'o32, 1'b0, PW, MW, PW,                   2'b00, 1'b1, 4'd10},
    '{3'd2, 6'o06, 1'b0, PW, MW, MW,                   2'b00, 1'b1, 4'd10},
    '{3'd4, 6'o54, 1'b0, NW, MW, NW,                   2'b00, 1'b1, 4'd10},
    '{3'd7, 6'o05, 1'b0, PW, MW, PW,                   2'b00, 1'b1, 4'd10}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [5:0]  field;
  logic        idx_sel;
  logic [30:0] reg_val;
  logic [30:0] mem_val;
  logic        out_valid;
  logic [30:0] result;
  logic [1:0]  cmp_code;
  logic        err;

  int checks;
  int errors;

  field_aligner dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op       (op),
    .field    (field),
    .idx_sel  (idx_sel),
    .reg_val  (reg_val),
    .mem_val  (mem_val),
    .out_valid(out_valid),
    .result   (result),
    .cmp_code (cmp_code),
    .err      (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    op = '0; field = '0; idx_sel = 1'b0; reg_val = '0; mem_val = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {out_valid, result, cmp_code, err}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {out_valid, result, cmp_code, err}, '0);

    // table walk, back-to-back
    for (int i = 0; i < NVEC; i++) begin
      op = VEC[i].op; field = VEC[i].fld; idx_sel = VEC[i].idx;
      reg_val = VEC[i].rv; mem_val = VEC[i].mv; in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VEC[i].rq, i),
            {out_valid, result, cmp_code, err},
            {1'b1, VEC[i].er, VEC[i].ec, VEC[i].ee});
    end

    // R1 hold: new operands without in_valid leave outputs unchanged
    in_valid = 1'b0;
    op = 3'd0; field = 6'o05; reg_val = MW; mem_val = NW; idx_sel = 1'b0;
    @(negedge clk);
    check("R1 hold", {out_valid, result, cmp_code, err}, {1'b0, PW, 2'b00, 1'b1});
    @(negedge clk);
    check("R1 hold 2", {out_valid, result, cmp_code, err}, {1'b0, PW, 2'b00, 1'b1});

    // R5 register value has no effect on store-zero
    in_valid = 1'b1; op = 3'd3; field = 6'o15; reg_val = w(1,63,63,63,63,63); mem_val = NW;
    @(negedge clk);
    check("R5 reg ignored", {out_valid, result, cmp_code, err}, {1'b1, w(1,0,0,0,0,0), 2'b00, 1'b0});

    // R6 both negative: -(1..5) vs -(11..55) is greater
    op = 3'd4; field = 6'o05; reg_val = NW; mem_val = w(1,11,22,33,44,55);
    @(negedge clk);
    check("R6 neg vs neg", {out_valid, cmp_code, err}, {1'b1, 2'b10, 1'b0});

    in_valid = 1'b0;
    @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule